// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block sits between an 8-bit bus that does ordinary single-cycle reads and writes and a behavioural flash array. The array has a main region and a small, separate information region. Writes to the main region count only as part of command sequences. The block decodes those sequences and turns them into three operations: byte program, page erase and mass erase. It runs each operation for a set number of clock cycles with a busy flag high. While the flag is high, reads return a status byte. An active-low write-protect pin locks the lowest 2K bytes of the main region.

A sequence always opens with two unlock writes: 0xAA to 0x5555, then 0x55 to 0x2AAA. A command byte written to 0x5555 follows. Command 0xA0 arms byte program, and the next write supplies the target address and the data. Command 0x80 arms erase. A second unlock pair must then follow, then either 0x30 to any address in the page to be cleared, or 0x10 to 0x5555 to clear the whole main region. Command 0xF0 clears the sticky protection error. A write that does not fit the sequence sends the decoder back to its start state. The info_sel input picks the information region as the target of a program, a page erase or a read.

The full device size is a 16-bit address space. The array depth is a parameter. The default build keeps 4K bytes of main region and takes the low address bits, so that elaboration stays small. A full-size build sets the depth to 16 address bits.

Top module: `flash_seq_ctrl`

## Requirements
- R1: The array changes only when a complete valid sequence is written: 0xAA@0x5555, 0x55@0x2AAA, then a command byte at 0x5555. Any write that breaks the sequence returns the decoder to its start state and changes no byte.
- R2: Byte program stores (old byte AND new data) at the addressed byte, so it can only clear bits. Busy stays high for exactly T_PROG cycles, and the byte is updated when busy falls.
- R3: Page erase (0x30 after the erase-setup sequence) sets to 0xFF every byte whose address bits [15:9] match those of the write address. All other bytes are kept. Busy lasts exactly T_PAGE cycles.
- R4: Mass erase (0x10 to 0x5555 after the erase-setup sequence) sets every main-region byte to 0xFF. Busy lasts exactly T_MASS cycles.
- R5: While wp_n is low, a byte program or page erase aimed at main addresses 0x0000 to 0x07FF is refused. Busy stays low, the target bytes are unchanged, and prot_err goes high and stays high.
- R6: A mass erase started while wp_n is low erases every main page except the four pages of 0x0000 to 0x07FF. It does not set prot_err.
- R7: The command 0xF0, written to 0x5555 after an unlock pair, clears prot_err.
- R8: A read accepted while busy is high returns the status byte. Bit 7 is 1, bit 5 equals prot_err, and all other bits are 0.
- R9: Writes presented while busy is high are ignored. They neither advance the sequence decoder nor change any byte.
- R10: A read accepted while idle returns, on the next cycle, the addressed byte. With info_sel high this is a byte of the information region. The information region is not covered by wp_n. It is programmed and page-erased with info_sel high on the final write, and no operation on it alters main bytes.
- R11: After reset, busy and prot_err are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, data appears next cycle |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| info_sel | input | 1 | Selects the information region |
| wp_n | input | 1 | Active-low boot-region write protect |
| bus_rdata | output | 8 | Read data or status byte |
| busy | output | 1 | Operation in progress |
| prot_err | output | 1 | Sticky protection refusal flag |

## Verification
Most faults show up as a wrong byte on a later read. A bad decoder state either launches an operation that was never asked for, which shows when an untouched byte reads back changed, or it drops a valid one, which shows when busy never rises on the write after the final sequence byte. A timer fault shows as a busy pulse of the wrong length, counted cycle by cycle from the clock edge that took the last write. Protection faults show within one cycle at prot_err and busy, and a later read shows whether the bytes of the boot pages survived.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int unsigned BUS_AW = 16;
  localparam int unsigned PAGE_SHIFT = 9;
  localparam logic [BUS_AW-1:0] BOOT_LIMIT = 16'h0800;
  localparam logic [BUS_AW-1:0] UNLOCK_A = 16'h5555;
  localparam logic [BUS_AW-1:0] UNLOCK_B = 16'h2AAA;

  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_PAGE, OP_MASS} op_e;

  function automatic logic in_boot(input logic [BUS_AW-1:0] a);
    return a < BOOT_LIMIT;
  endfunction

  function automatic logic [BUS_AW-PAGE_SHIFT-1:0] page_of(input logic [BUS_AW-1:0] a);
    return a[BUS_AW-1:PAGE_SHIFT];
  endfunction

  function automatic logic [7:0] prog_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic [7:0] status_byte(input logic err);
    return {1'b1, 1'b0, err, 5'b0};
  endfunction
endpackage

// File: rtl/seq_decoder.sv
module seq_decoder
  import flash_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              busy_in,
  output logic              go,
  output op_e               go_op,
  output logic              clr_err
);
  typedef enum logic [2:0] {S_IDLE, S_UNL1, S_CMD, S_PADDR, S_EUNL0, S_EUNL1, S_ECMD} st_e;
  st_e state, state_nx;
  logic wr_ok;
  assign wr_ok = wr_en && !busy_in;

  always_comb begin
    state_nx = state;
    go = 1'b0;
    go_op = OP_NONE;
    clr_err = 1'b0;
    if (wr_ok) begin
      state_nx = S_IDLE;
      unique case (state)
        S_IDLE:  if (addr == UNLOCK_A && wdata == 8'hAA) state_nx = S_UNL1;
        S_UNL1:  if (addr == UNLOCK_B && wdata == 8'h55) state_nx = S_CMD;
        S_CMD:   if (addr == UNLOCK_A) begin
                   if (wdata == 8'hA0) state_nx = S_PADDR;
                   else if (wdata == 8'h80) state_nx = S_EUNL0;
                   else if (wdata == 8'hF0) clr_err = 1'b1;
                 end
        S_PADDR: begin go = 1'b1; go_op = OP_PROG; end
        S_EUNL0: if (addr == UNLOCK_A && wdata == 8'hAA) state_nx = S_EUNL1;
        S_EUNL1: if (addr == UNLOCK_B && wdata == 8'h55) state_nx = S_ECMD;
        S_ECMD:  if (wdata == 8'h30) begin go = 1'b1; go_op = OP_PAGE; end
                 else if (wdata == 8'h10 && addr == UNLOCK_A) begin go = 1'b1; go_op = OP_MASS; end
        default: state_nx = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= S_IDLE;
    else state <= state_nx;

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_in |=> state == $past(state));
  // R1
  go_from_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (state == S_PADDR || state == S_ECMD));
endmodule

// File: rtl/op_timer.sv
module op_timer
  import flash_seq_pkg::*;
#(
  parameter int unsigned T_PROG = 4,
  parameter int unsigned T_PAGE = 20,
  parameter int unsigned T_MASS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  op_e  op,
  output logic busy,
  output logic fin
);
  localparam int unsigned T_MAX = (T_MASS > T_PAGE) ? ((T_MASS > T_PROG) ? T_MASS : T_PROG)
                                                    : ((T_PAGE > T_PROG) ? T_PAGE : T_PROG);
  localparam int unsigned CW = $clog2(T_MAX + 1);
  logic [CW-1:0] cnt, load_val;

  always_comb
    unique case (op)
      OP_PROG: load_val = CW'(T_PROG);
      OP_PAGE: load_val = CW'(T_PAGE);
      OP_MASS: load_val = CW'(T_MASS);
      default: load_val = '0;
    endcase

  assign busy = cnt != '0;
  assign fin = cnt == CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (start) cnt <= load_val;
    else if (busy) cnt <= cnt - CW'(1);

  // R9
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R2
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> cnt == $past(cnt) - CW'(1));
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_seq_pkg::*;
#(
  parameter int unsigned ARR_AW = 12,
  parameter int unsigned INFO_AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  op_e               op,
  input  logic [BUS_AW-1:0] op_addr,
  input  logic [7:0]        op_data,
  input  logic              op_info,
  input  logic              keep_boot,
  input  logic [BUS_AW-1:0] rd_addr,
  input  logic              rd_info,
  output logic [7:0]        rd_byte
);
  localparam int unsigned MAIN_N = 1 << ARR_AW;
  localparam int unsigned INFO_N = 1 << INFO_AW;
  logic [7:0] main_mem [MAIN_N];
  logic [7:0] info_mem [INFO_N];
  logic [ARR_AW-1:0] m_idx;
  logic [INFO_AW-1:0] i_idx;
  logic [7:0] old_byte;
  logic do_prog;

  assign m_idx = op_addr[ARR_AW-1:0];
  assign i_idx = op_addr[INFO_AW-1:0];
  assign old_byte = op_info ? info_mem[i_idx] : main_mem[m_idx];
  assign do_prog = commit && op == OP_PROG;
  assign rd_byte = rd_info ? info_mem[rd_addr[INFO_AW-1:0]] : main_mem[rd_addr[ARR_AW-1:0]];

  initial begin
    for (int i = 0; i < MAIN_N; i++) main_mem[i] = 8'hFF;
    for (int i = 0; i < INFO_N; i++) info_mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (do_prog && !op_info) main_mem[m_idx] <= prog_merge(old_byte, op_data);
    if (do_prog && op_info) info_mem[i_idx] <= prog_merge(old_byte, op_data);
    if (commit && !op_info && op == OP_PAGE)
      for (int i = 0; i < MAIN_N; i++)
        if (page_of(BUS_AW'(i)) == page_of(op_addr)) main_mem[i] <= 8'hFF;
    if (commit && op_info && op == OP_PAGE)
      for (int i = 0; i < INFO_N; i++) info_mem[i] <= 8'hFF;
    if (commit && op == OP_MASS)
      for (int i = 0; i < MAIN_N; i++)
        if (!(keep_boot && in_boot(BUS_AW'(i)))) main_mem[i] <= 8'hFF;
  end

  // R2
  prog_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_prog && !op_info) |=> main_mem[$past(m_idx)] == ($past(old_byte) & $past(op_data)));
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int unsigned ARR_AW = 12,
  parameter int unsigned INFO_AW = 9,
  parameter int unsigned T_PROG = 4,
  parameter int unsigned T_PAGE = 20,
  parameter int unsigned T_MASS = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        info_sel,
  input  logic        wp_n,
  output logic [7:0]  bus_rdata,
  output logic        busy,
  output logic        prot_err
);
  logic go, clr_err, refuse, start_ok, fin;
  op_e go_op, op_q;
  logic [BUS_AW-1:0] addr_q;
  logic [7:0] data_q, rd_byte;
  logic info_q, keep_boot_q;

  seq_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .busy_in(busy), .go(go), .go_op(go_op), .clr_err(clr_err));

  assign refuse = go && go_op != OP_MASS && !info_sel && !wp_n && in_boot(bus_addr);
  assign start_ok = go && !refuse;

  op_timer #(.T_PROG(T_PROG), .T_PAGE(T_PAGE), .T_MASS(T_MASS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start_ok), .op(go_op), .busy(busy), .fin(fin));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      op_q <= OP_NONE; addr_q <= '0; data_q <= '0; info_q <= 1'b0; keep_boot_q <= 1'b0;
    end else if (start_ok) begin
      op_q <= go_op; addr_q <= bus_addr; data_q <= bus_wdata;
      info_q <= info_sel; keep_boot_q <= !wp_n;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prot_err <= 1'b0;
    else if (refuse) prot_err <= 1'b1;
    else if (clr_err) prot_err <= 1'b0;

  flash_array #(.ARR_AW(ARR_AW), .INFO_AW(INFO_AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(fin), .op(op_q), .op_addr(addr_q), .op_data(data_q),
    .op_info(info_q), .keep_boot(keep_boot_q), .rd_addr(bus_addr), .rd_info(info_sel),
    .rd_byte(rd_byte));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else if (bus_re) bus_rdata <= busy ? status_byte(prot_err) : rd_byte;

  // R5
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_err) |-> $past(refuse) && !$past(busy));
  // R1
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_ok));
  // R8
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && busy) |=> bus_rdata[7] && bus_rdata[6] == 1'b0 && bus_rdata[4:0] == 5'b0);
endmodule

// File: tb/flash_seq_ctrl_bench.sv
module flash_seq_ctrl_bench;
  localparam int TP = 4, TG = 20, TM = 40;
  logic clk = 0, rst_n = 0, we = 0, re = 0, isel = 0, wp_n = 1;
  logic [15:0] addr = 0;
  logic [7:0] wd = 0, rdata;
  logic busy, perr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_seq_ctrl #(.T_PROG(TP), .T_PAGE(TG), .T_MASS(TM)) u_flash_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_re(re), .bus_addr(addr), .bus_wdata(wd),
    .info_sel(isel), .wp_n(wp_n), .bus_rdata(rdata), .busy(busy), .prot_err(perr));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wd = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); re = 1; addr = a;
    @(negedge clk); re = 0; d = rdata;
  endtask

  task automatic unlock();
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] d);
    unlock(); wr(16'h5555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_setup();
    unlock(); wr(16'h5555, 8'h80); unlock();
  endtask

  task automatic t_reset();
    chk("R11 busy", busy, 0); chk("R11 prot_err", perr, 0);
  endtask

  task automatic t_mass();
    int n; logic [7:0] d;
    erase_setup(); wr(16'h5555, 8'h10); busy_len(n);
    chk("R4 busy cycles", n, TM);
    rd(16'h0000, d); chk("R4 byte 0", d, 8'hFF);
    rd(16'h0FFF, d); chk("R4 top byte", d, 8'hFF);
  endtask

  task automatic t_prog();
    int n; logic [7:0] d;
    prog(16'h0123, 8'h5A); busy_len(n);
    chk("R2 busy cycles", n, TP);
    rd(16'h0123, d); chk("R2 first program", d, 8'h5A);
    prog(16'h0123, 8'h0F); busy_len(n);
    rd(16'h0123, d); chk("R2 AND merge", d, 8'h0A);
  endtask

  task automatic t_status();
    int n; logic [7:0] d;
    erase_setup(); wr(16'h0C00, 8'h30);
    rd(16'h0C00, d); chk("R8 status byte", d, 8'h80);
    busy_len(n);
  endtask

  task automatic t_bad_seq();
    logic [7:0] d;
    wr(16'h0200, 8'h00);
    rd(16'h0200, d); chk("R1 plain write", d, 8'hFF);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h54); wr(16'h5555, 8'hA0); wr(16'h0200, 8'h00);
    chk("R1 broken seq busy", busy, 0);
    rd(16'h0200, d); chk("R1 broken seq data", d, 8'hFF);
  endtask

  task automatic t_protect();
    int n; logic [7:0] d;
    wp_n = 0;
    prog(16'h0100, 8'h00);
    chk("R5 prog refused busy", busy, 0); chk("R5 prot_err set", perr, 1);
    rd(16'h0100, d); chk("R5 byte kept", d, 8'hFF);
    erase_setup(); wr(16'h0123, 8'h30);
    chk("R5 page refused busy", busy, 0);
    rd(16'h0123, d); chk("R5 boot page kept", d, 8'h0A);
    erase_setup(); wr(16'h0C00, 8'h30);
    rd(16'h0C00, d); chk("R8 status with err", d, 8'hA0);
    busy_len(n);
    unlock(); wr(16'h5555, 8'hF0);
    chk("R7 prot_err cleared", perr, 0);
    prog(16'h0900, 8'h33); busy_len(n);
    rd(16'h0900, d); chk("R5 outside boot programs", d, 8'h33);
    wp_n = 1;
  endtask

  task automatic t_page();
    int n; logic [7:0] d;
    prog(16'h0A10, 8'h11); busy_len(n);
    prog(16'h0C00, 8'h22); busy_len(n);
    prog(16'h09FF, 8'h44); busy_len(n);
    erase_setup(); wr(16'h0BFE, 8'h30); busy_len(n);
    chk("R3 busy cycles", n, TG);
    rd(16'h0A10, d); chk("R3 page cleared", d, 8'hFF);
    rd(16'h0C00, d); chk("R3 next page kept", d, 8'h22);
    rd(16'h09FF, d); chk("R3 prev page kept", d, 8'h44);
  endtask

  task automatic t_mass_wp();
    int n; logic [7:0] d;
    wp_n = 0;
    erase_setup(); wr(16'h5555, 8'h10); busy_len(n);
    chk("R6 no error", perr, 0);
    rd(16'h0123, d); chk("R6 boot kept", d, 8'h0A);
    rd(16'h0900, d); chk("R6 other erased", d, 8'hFF);
    rd(16'h0C00, d); chk("R6 other erased 2", d, 8'hFF);
    wp_n = 1;
  endtask

  task automatic t_info();
    int n; logic [7:0] d;
    wp_n = 0;
    unlock(); wr(16'h5555, 8'hA0); isel = 1; wr(16'h0010, 8'h3C); isel = 0; busy_len(n);
    chk("R10 info not protected", perr, 0);
    isel = 1; rd(16'h0010, d); isel = 0; chk("R10 info read", d, 8'h3C);
    rd(16'h0010, d); chk("R10 main untouched", d, 8'hFF);
    erase_setup(); isel = 1; wr(16'h0000, 8'h30); isel = 0; busy_len(n);
    isel = 1; rd(16'h0010, d); isel = 0; chk("R10 info erased", d, 8'hFF);
    rd(16'h0123, d); chk("R10 main kept on info erase", d, 8'h0A);
    wp_n = 1;
  endtask

  task automatic t_busy_writes();
    int n; logic [7:0] d;
    erase_setup(); wr(16'h5555, 8'h10);
    prog(16'h0E00, 8'h00);
    busy_len(n);
    wr(16'h0E00, 8'h00);
    chk("R9 no launch after busy", busy, 0);
    rd(16'h0E00, d); chk("R9 byte unchanged", d, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_mass(); t_prog(); t_status(); t_bad_seq(); t_protect();
    t_page(); t_mass_wp(); t_info(); t_busy_writes();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule